// File: doc/BRIEF.md
# Frame Sync Protection Window Unit

This block decides which raw frame-sync detections from a channel-bit stream may steer the frame timing. A free-running frame counter steps once per bit clock and wraps every 588 clocks. Its position zero is the expected sync position. While the unit is locked, a raw sync pulse realigns the counter only when it falls inside an acceptance window centred on that position. A pulse outside the window is dropped, so a false detection cannot pull the frame timing away.

A frame ends when its window closes. If no accepted sync arrived before that point, the frame counts as a miss. After a selectable number of consecutive misses the unit drops lock and enters a resync state. In that state the next raw sync of any phase realigns the counter. The following sync that lands inside the window restores lock. The unit leaves reset in the resync state, so the first detection sets the frame phase.

Top module: `fsp_sync_guard`

## Requirements
- R1: With no sync accepted, `frame_stb_o` is a one-clock pulse that repeats every 588 clocks.
- R2: While `rst_i` is high and right after it, `resync_o` is 1, `lock_o` is 0, `frame_stb_o` is 0 and `in_win_o` is 0.
- R3: While `resync_o` is 1, a sync pulse at any counter position realigns the counter. `frame_stb_o` is 1 in the cycle after the edge that samples the pulse and again 588 clocks later. If the pulse was outside the window, `resync_o` stays 1.
- R4: While locked, a sync sampled at most W clocks before or after the expected position is accepted and realigns the counter. A sync sampled further away is ignored: the strobe keeps its old phase and `lock_o` stays 1.
- R5: `win_sel_i` = 0 sets W = 3. `win_sel_i` = 1 sets W = 7.
- R6: An accepted in-window sync sets `lock_o` to 1, clears `resync_o` and clears the miss count.
- R7: A frame with no accepted sync counts one miss. The miss is counted at the clock edge where the counter reads W after the expected position. The edge that counts miss N sets `resync_o` to 1 and `lock_o` to 0. Counting stops while resyncing.
- R8: `thr_sel_i` picks N: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12.
- R9: `in_win_o` is registered. After the edge where the counter reads k clocks past the expected position, it is 1 exactly when k <= W or k >= 588 - W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_det_i | input | 1 | Raw sync-pattern detect pulse |
| thr_sel_i | input | 2 | Miss threshold select (2/4/8/12) |
| win_sel_i | input | 1 | Window half-width select (0: ±3, 1: ±7) |
| frame_stb_o | output | 1 | Frame start strobe |
| in_win_o | output | 1 | Counter is inside the acceptance window |
| resync_o | output | 1 | Resync state active |
| lock_o | output | 1 | Frame timing locked |

## Verification
Sync pulses are placed at offsets on both sides of the expected position: at the window edge, one clock beyond it, and at ±6. Run under both window widths, these separate the ±3 window from the ±7 window and catch off-by-one errors at each edge. Long gaps without any sync, run at every threshold setting, check that resync rises on exactly the Nth missed window close and not one clock earlier. A run of misses broken by one accepted sync shows that the miss count really resets. An off-phase pulse sent while resyncing shows that any sync realigns the counter, but only an in-window sync restores lock.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    THR_SEL_A = 2'd0,
    THR_SEL_B = 2'd1,
    THR_SEL_C = 2'd2,
    THR_SEL_D = 2'd3
  } thr_sel_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fsp_frame_counter.sv
module fsp_frame_counter #(
  parameter int FRAME_LEN = 588,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             realign_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pos_zero_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  // A realigning sync marks the current cycle as position zero.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (realign_i) begin
      cnt_q <= CNT_W'(1);
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o      = cnt_q;
  assign pos_zero_o = realign_i || (cnt_q == '0);

endmodule

// File: rtl/fsp_window.sv
module fsp_window #(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_NARROW = 3,
  parameter int WIN_WIDE   = 7,
  localparam int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             win_sel_i,
  output logic             in_win_o,
  output logic             close_o
);

  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] half_w;

  always_comb begin
    half_w   = win_sel_i ? CNT_W'(WIN_WIDE) : CNT_W'(WIN_NARROW);
    in_win_o = (cnt_i <= half_w) || (cnt_i >= (LEN_V - half_w));
    close_o  = (cnt_i == half_w);
  end

endmodule

// File: rtl/fsp_miss_tracker.sv
module fsp_miss_tracker #(
  parameter int MISS_N0 = 2,
  parameter int MISS_N1 = 4,
  parameter int MISS_N2 = 8,
  parameter int MISS_N3 = 12,
  localparam int MISS_MAX = fsp_pkg::max4(MISS_N0, MISS_N1, MISS_N2, MISS_N3),
  localparam int MISS_W   = $clog2(MISS_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       proper_i,
  input  logic       close_i,
  input  logic [1:0] thr_sel_i,
  output logic       resync_o,
  output logic       lock_o
);
  import fsp_pkg::*;

  logic [MISS_W-1:0] thresh;
  logic [MISS_W-1:0] miss_q;
  logic [MISS_W-1:0] miss_inc;
  logic              hit_q;
  logic              resync_q;
  logic              lock_q;

  always_comb begin
    unique case (thr_sel_e'(thr_sel_i))
      THR_SEL_A: thresh = MISS_W'(MISS_N0);
      THR_SEL_B: thresh = MISS_W'(MISS_N1);
      THR_SEL_C: thresh = MISS_W'(MISS_N2);
      default:   thresh = MISS_W'(MISS_N3);
    endcase
    miss_inc = miss_q + MISS_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      miss_q   <= '0;
      hit_q    <= 1'b0;
      resync_q <= 1'b1;
      lock_q   <= 1'b0;
    end else if (proper_i) begin
      miss_q   <= '0;
      hit_q    <= 1'b1;
      resync_q <= 1'b0;
      lock_q   <= 1'b1;
    end else if (close_i) begin
      hit_q <= 1'b0;
      if (!hit_q && !resync_q) begin
        miss_q <= miss_inc;
        if (miss_inc >= thresh) begin
          resync_q <= 1'b1;
          lock_q   <= 1'b0;
        end
      end
    end
  end

  assign resync_o = resync_q;
  assign lock_o   = lock_q;

endmodule

// File: rtl/fsp_sync_guard.sv
module fsp_sync_guard #(
  parameter int FRAME_LEN  = 588,
  parameter int WIN_NARROW = 3,
  parameter int WIN_WIDE   = 7,
  parameter int MISS_N0    = 2,
  parameter int MISS_N1    = 4,
  parameter int MISS_N2    = 8,
  parameter int MISS_N3    = 12
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sync_det_i,
  input  logic [1:0] thr_sel_i,
  input  logic       win_sel_i,
  output logic       frame_stb_o,
  output logic       in_win_o,
  output logic       resync_o,
  output logic       lock_o
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] cnt;
  logic             pos_zero;
  logic             in_win;
  logic             close;
  logic             proper;
  logic             realign;
  logic             resync;
  logic             lock;
  logic             stb_q;
  logic             in_win_q;

  assign proper  = sync_det_i && in_win;
  assign realign = sync_det_i && (in_win || resync);

  fsp_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .realign_i  (realign),
    .cnt_o      (cnt),
    .pos_zero_o (pos_zero)
  );

  fsp_window #(
    .FRAME_LEN  (FRAME_LEN),
    .WIN_NARROW (WIN_NARROW),
    .WIN_WIDE   (WIN_WIDE)
  ) u_win (
    .cnt_i     (cnt),
    .win_sel_i (win_sel_i),
    .in_win_o  (in_win),
    .close_o   (close)
  );

  fsp_miss_tracker #(
    .MISS_N0 (MISS_N0),
    .MISS_N1 (MISS_N1),
    .MISS_N2 (MISS_N2),
    .MISS_N3 (MISS_N3)
  ) u_miss (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .proper_i  (proper),
    .close_i   (close),
    .thr_sel_i (thr_sel_i),
    .resync_o  (resync),
    .lock_o    (lock)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stb_q    <= 1'b0;
      in_win_q <= 1'b0;
    end else begin
      stb_q    <= pos_zero;
      in_win_q <= in_win;
    end
  end

  assign frame_stb_o = stb_q;
  assign in_win_o    = in_win_q;
  assign resync_o    = resync;
  assign lock_o      = lock;

endmodule

// File: rtl/fsp_sync_guard_chk.sv
module fsp_sync_guard_chk #(
  parameter int FRAME_LEN = 588,
  localparam int GAP_W    = $clog2(FRAME_LEN + 2)
) (
  input logic clk_i,
  input logic rst_i,
  input logic sync_det_i,
  input logic frame_stb_o,
  input logic in_win_o,
  input logic resync_o,
  input logic lock_o
);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q || frame_stb_o;
      if (frame_stb_o) gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(FRAME_LEN + 1)) gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R1: a strobe comes from a full period or from a realigning sync
  p_period_r1: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
    frame_stb_o |-> ($past(sync_det_i) || gap_q == GAP_W'(FRAME_LEN)));

  // R1: a full period without a strobe never happens
  p_period_due_r1: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
    (gap_q == GAP_W'(FRAME_LEN)) |-> frame_stb_o);

  // R2: state right after reset
  p_reset_state_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (resync_o && !lock_o && !frame_stb_o));

  // R6: lock is only gained through an in-window sync
  p_lock_gain_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lock_o) |-> ($past(sync_det_i) && in_win_o));

  // R6: resync only ends through an in-window sync
  p_resync_end_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(resync_o) |-> ($past(sync_det_i) && in_win_o));

  // R7: resync is entered only from lock, and lock drops with it
  p_resync_entry_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(resync_o) |-> $fell(lock_o));

  // R7: lock and resync are exclusive
  p_state_excl_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({resync_o, lock_o}) == 1);

endmodule

bind fsp_sync_guard fsp_sync_guard_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .sync_det_i  (sync_det_i),
  .frame_stb_o (frame_stb_o),
  .in_win_o    (in_win_o),
  .resync_o    (resync_o),
  .lock_o      (lock_o)
);

// File: tb/fsp_sync_guard_tb.sv
`timescale 1ns/1ps
module fsp_sync_guard_tb_top;

  localparam int LEN = 588;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_det = 1'b0;
  logic [1:0] thr_sel = 2'd3;
  logic       win_sel = 1'b1;
  logic       frame_stb, in_win, resync, lock;

  int checks = 0;
  int failures = 0;
  int ecount = 0;
  int anchor = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsp_sync_guard dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .sync_det_i  (sync_det),
    .thr_sel_i   (thr_sel),
    .win_sel_i   (win_sel),
    .frame_stb_o (frame_stb),
    .in_win_o    (in_win),
    .resync_o    (resync),
    .lock_o      (lock)
  );

  // {win_sel, offset from expected position, accepted}
  localparam logic [9:0] VEC [12] = '{
    {1'b1,  8'sd0, 1'b1}, {1'b1,  8'sd7, 1'b1}, {1'b1, -8'sd7, 1'b1},
    {1'b1,  8'sd8, 1'b0}, {1'b1, -8'sd8, 1'b0}, {1'b0,  8'sd3, 1'b1},
    {1'b0, -8'sd3, 1'b1}, {1'b0,  8'sd4, 1'b0}, {1'b0, -8'sd4, 1'b0},
    {1'b0,  8'sd6, 1'b0}, {1'b1,  8'sd6, 1'b1}, {1'b0,  8'sd0, 1'b1}
  };

  task automatic tick(input logic s);
    @(negedge clk);
    sync_det = s;
    @(posedge clk);
    ecount++;
    #1;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got %0d exp %0d (edge %0d)", tag, got, exp, ecount);
    end
  endtask

  function automatic int thr_of(input int s);
    case (s)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog got 0 exp 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0, s1, nstb;
    repeat (3) tick(1'b0);
    // R2 reset state
    check("R2 resync", resync, 1);
    check("R2 lock", lock, 0);
    check("R2 strobe", frame_stb, 0);
    check("R2 in_win", in_win, 0);
    rst = 1'b0;

    // R1 free-running period
    s0 = -1; s1 = -1; nstb = 0;
    for (int i = 0; i < 1200; i++) begin
      tick(1'b0);
      if (frame_stb) begin
        nstb++;
        if (s0 < 0) s0 = ecount; else if (s1 < 0) s1 = ecount;
      end
    end
    check("R1 strobe count", nstb, 3);
    check("R1 period", s1 - s0, LEN);
    check("R2 still resync", resync, 1);

    // R3 off-phase sync realigns while resyncing
    tick(1'b1);
    anchor = ecount;
    check("R3 realign strobe", frame_stb, 1);
    check("R3 resync kept", resync, 1);
    while (ecount < anchor + LEN - 1) tick(1'b0);
    check("R3 no early strobe", frame_stb, 0);
    tick(1'b1);
    check("R3 strobe one period later", frame_stb, 1);
    check("R6 resync cleared", resync, 0);
    check("R6 lock set", lock, 1);
    anchor = ecount;

    // R9 / R5 in-window flag edges
    win_sel = 1'b0;
    while (ecount < anchor + 3) tick(1'b0);
    check("R9 narrow +3", in_win, 1);
    tick(1'b0);
    check("R5 narrow +4", in_win, 0);
    win_sel = 1'b1;
    while (ecount < anchor + 7) tick(1'b0);
    check("R9 wide +7", in_win, 1);
    tick(1'b0);
    check("R5 wide +8", in_win, 0);
    while (ecount < anchor + LEN - 8) tick(1'b0);
    check("R9 wide -8", in_win, 0);
    tick(1'b0);
    check("R9 wide -7", in_win, 1);
    while (ecount < anchor + LEN - 1) tick(1'b0);
    tick(1'b1);
    anchor = ecount;
    check("R6 relock", lock, 1);

    // R4 / R5 window acceptance table
    for (int v = 0; v < 12; v++) begin
      int d, nat, tgt, last;
      bit acc, bad;
      logic exp_stb;
      win_sel = VEC[v][9];
      d   = int'($signed(VEC[v][8:1]));
      acc = VEC[v][0];
      nat = anchor + LEN;
      tgt = nat + d;
      last = (tgt > nat) ? tgt : nat;
      bad = 1'b0;
      while (ecount < last) begin
        tick((ecount + 1) == tgt);
        exp_stb = (acc && ecount == tgt) || (ecount == nat && !(acc && d < 0));
        if (frame_stb !== exp_stb) begin
          bad = 1'b1;
          $display("FAIL R4 vec %0d strobe got %0b exp %0b at edge %0d", v, frame_stb, exp_stb, ecount);
        end
      end
      checks++;
      if (bad) failures++;
      check($sformatf("R4 lock held vec %0d", v), lock, 1);
      anchor = acc ? tgt : nat;
    end

    // R7 / R8 threshold for each select value
    win_sel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int n;
      thr_sel = 2'(s);
      n = thr_of(s);
      while (ecount < anchor + LEN * n + 6) tick(1'b0);
      check($sformatf("R8 sel %0d resync before Nth miss", s), resync, 0);
      check($sformatf("R8 sel %0d lock before Nth miss", s), lock, 1);
      tick(1'b0);
      check($sformatf("R7 sel %0d resync at Nth miss", s), resync, 1);
      check($sformatf("R7 sel %0d lock dropped", s), lock, 0);
      repeat (50) tick(1'b0);
      tick(1'b1);
      anchor = ecount;
      check("R3 resync realign strobe", frame_stb, 1);
      check("R3 resync held after off-window sync", resync, 1);
      while (ecount < anchor + LEN - 1) tick(1'b0);
      tick(1'b1);
      check("R6 lock regained", lock, 1);
      anchor = ecount;
    end

    // R6 miss count cleared by an accepted sync
    thr_sel = 2'd1;
    while (ecount < anchor + LEN * 4 - 1) tick(1'b0);
    tick(1'b1);
    check("R6 lock after three misses", lock, 1);
    anchor = ecount;
    while (ecount < anchor + LEN * 4 + 6) tick(1'b0);
    check("R6 miss count restarted", resync, 0);
    tick(1'b0);
    check("R7 resync after four fresh misses", resync, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule